// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Checker

This block sits on the receive path after preamble removal. It sees each incoming frame as a stream of bytes, one byte per accepted beat. The stream runs from the first destination-address byte through the last frame check sequence byte. On the final beat a 3-bit count gives the number of stray bits received after the last whole byte. While the bytes arrive, the block measures the length, runs a CRC-32 over every byte, and captures the two-byte length/type word.

When the frame ends, the block decides whether the frame goes into the receive buffer or is dropped. It also produces a header status byte to be written ahead of the stored packet, and one-cycle event pulses for a status register. An errored frame is kept only when the matching permission is set: short frames need the short-accept control, and CRC or alignment faults need the bad-accept control. The buffer-full input is sampled on the final beat. A frame that would otherwise be kept is then rejected and reported as an overflow.

The byte input is a valid/ready stream. A beat transfers only on a clock edge where both `in_valid` and `in_ready` are high. The source must hold `in_data`, `in_last` and `in_tail_bits` steady while `in_valid` is high and `in_ready` is low. `in_ready` drops for exactly the one cycle in which the decision is presented, and is high otherwise. The configuration inputs and `buf_full` are plain levels, read on the final beat.

Top module: `rx_frame_gate`

## Requirements
- R1: After reset `in_ready` is high. It is low exactly in the cycles where `dec_valid` is high, and no beat transfers then.
- R2: `dec_valid` is high for exactly one cycle, the cycle right after the edge that accepted the beat carrying `in_last`. It is low at all other times.
- R3: A frame with fewer than 64 accepted bytes (fewer than 60 without the 4 CRC bytes) sets header bit 3 (short).
- R4: A nonzero `in_tail_bits` on the final beat sets header bit 2 (alignment).
- R5: CRC-32 (reflected polynomial EDB88320h, preset all ones) runs over every byte including the check bytes. If the register does not end at the good residue, header bit 1 (CRC) is set. The good residue is C704DD7Bh in most-significant-bit-first form.
- R6: If `cfg_remote_en` is high on the final beat and bytes 12 and 13 (counting from 0) are 09h then 00h, header bit 4 (remote control) is set. A frame shorter than 14 bytes never sets it.
- R7: A frame is acceptable unless it is short with `cfg_accept_short` low, or has a CRC or alignment error with `cfg_accept_bad` low. An unacceptable frame gives `dec_store` = 0.
- R8: While `dec_valid` is high, `hdr_status` carries bits 4..1 as defined above and zeros in bits 7, 6, 5 and 0. While `dec_valid` is low, `hdr_status` is all zeros.
- R9: If `buf_full` is high on the final beat of an acceptable frame, `dec_store` is 0 and `evt_overflow` pulses. An unacceptable frame never raises `evt_overflow`.
- R10: `evt_rx_pkt` pulses exactly when `dec_store` is 1. `evt_remote`, `evt_short`, `evt_align` and `evt_crc` pulse with their header bits only for a stored frame. No event is high outside `dec_valid`.
- R11: During and right after reset, `dec_valid`, `dec_store`, `hdr_status` and all event outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat offered |
| in_ready | output | 1 | Byte beat can be taken |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Beat carries the final byte of the frame |
| in_tail_bits | input | 3 | Stray bits after the final byte, read with `in_last` |
| cfg_accept_bad | input | 1 | Keep frames with CRC or alignment errors |
| cfg_accept_short | input | 1 | Keep short frames |
| cfg_remote_en | input | 1 | Enable detection of the remote-control type |
| buf_full | input | 1 | Receive buffer cannot take a frame |
| dec_valid | output | 1 | Decision cycle |
| dec_store | output | 1 | Write frame to buffer |
| hdr_status | output | 8 | Header status byte |
| evt_rx_pkt | output | 1 | Frame stored pulse |
| evt_remote | output | 1 | Stored remote-control frame pulse |
| evt_short | output | 1 | Stored short frame pulse |
| evt_align | output | 1 | Stored misaligned frame pulse |
| evt_crc | output | 1 | Stored bad-CRC frame pulse |
| evt_overflow | output | 1 | Acceptable frame rejected for space |

## Verification
Several flags are decided on the same final-beat edge. The case that matters most is a short frame of type 0900h that is kept under the short-accept control, because the remote-control and short events must then pulse in the same decision cycle. A second case is a short frame with a CRC fault while only short frames are permitted: the two permissions have to be combined, and the frame must be dropped. A third is `buf_full` rising on the final beat of an acceptable frame, where overflow must replace the store. A behavioural model in the bench computes the CRC from the byte list directly. The bench compares every output against that model on each clock, while frames arrive with random gaps in `in_valid`.

// File: rtl/rxacc_pkg.sv
package rxacc_pkg;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;
  // good residue C704DD7B in msb-first form, bit-reversed here
  localparam logic [31:0] CRC_GOOD_REFL = 32'hDEBB20E3;

  localparam int HDR_REMOTE = 4;
  localparam int HDR_SHORT  = 3;
  localparam int HDR_ALIGN  = 2;
  localparam int HDR_CRC    = 1;

  typedef struct packed {
    logic remote;
    logic short_err;
    logic align_err;
    logic crc_err;
  } rx_flags_t;

  function automatic logic [31:0] crc32_byte(logic [31:0] c_in, logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int k = 0; k < 8; k++) begin
      if (c[0] ^ d[k]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/rxacc_crc32.sv
module rxacc_crc32
  import rxacc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       last,
  input  logic [7:0] data,
  output logic       crc_ok_nxt
);
  logic [31:0] crc_q;
  logic [31:0] crc_nxt;

  always_comb begin
    crc_nxt    = crc32_byte(crc_q, data);
    crc_ok_nxt = (crc_nxt == CRC_GOOD_REFL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          crc_q <= CRC_INIT;
    else if (beat) begin
      if (last)          crc_q <= CRC_INIT;
      else               crc_q <= crc_nxt;
    end
  end

  // R5: the register restarts from the preset for the next frame
  assert_crc_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last) |=> (crc_q == CRC_INIT));
  assert_crc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(crc_q));
endmodule

// File: rtl/rxacc_field_track.sv
module rxacc_field_track #(
  parameter int CNT_W    = 11,
  parameter int TYPE_OFS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             last,
  input  logic [7:0]       data,
  output logic [CNT_W-1:0] len_nxt,
  output logic [15:0]      type_nxt,
  output logic             type_seen
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] POS_HI   = CNT_W'(TYPE_OFS);
  localparam logic [CNT_W-1:0] POS_LO   = CNT_W'(TYPE_OFS + 1);
  localparam logic [CNT_W-1:0] POS_DONE = CNT_W'(TYPE_OFS + 2);

  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      type_q;

  always_comb begin
    len_nxt  = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    type_nxt = type_q;
    if (cnt_q == POS_HI) type_nxt[15:8] = data;
    if (cnt_q == POS_LO) type_nxt[7:0]  = data;
    type_seen = (len_nxt >= POS_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      type_q <= '0;
    end else if (beat) begin
      if (last) begin
        cnt_q  <= '0;
        type_q <= '0;
      end else begin
        cnt_q  <= len_nxt;
        type_q <= type_nxt;
      end
    end
  end

  // R3: length count starts from zero for every frame
  assert_len_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last) |=> (cnt_q == '0));
  assert_len_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(cnt_q));
endmodule

// File: rtl/rxacc_decide.sv
module rxacc_decide
  import rxacc_pkg::*;
#(
  parameter int          CNT_W       = 11,
  parameter int          MIN_LEN     = 60,
  parameter int          FCS_BYTES   = 4,
  parameter logic [15:0] REMOTE_TYPE = 16'h0900
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof,
  input  logic [CNT_W-1:0] len,
  input  logic             crc_ok,
  input  logic [2:0]       tail_bits,
  input  logic [15:0]      type_val,
  input  logic             type_seen,
  input  logic             cfg_accept_bad,
  input  logic             cfg_accept_short,
  input  logic             cfg_remote_en,
  input  logic             buf_full,
  output logic             dec_valid,
  output logic             dec_store,
  output logic [7:0]       hdr_status,
  output logic             evt_rx_pkt,
  output logic             evt_remote,
  output logic             evt_short,
  output logic             evt_align,
  output logic             evt_crc,
  output logic             evt_overflow
);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(MIN_LEN + FCS_BYTES);

  rx_flags_t fl;
  logic      allowed;

  always_comb begin
    fl.short_err = (len < SHORT_LIM);
    fl.align_err = |tail_bits;
    fl.crc_err   = !crc_ok;
    fl.remote    = cfg_remote_en && type_seen && (type_val == REMOTE_TYPE);
    allowed = !(fl.short_err && !cfg_accept_short) &&
              !((fl.crc_err || fl.align_err) && !cfg_accept_bad);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !eof) begin
      dec_valid    <= 1'b0;
      dec_store    <= 1'b0;
      hdr_status   <= '0;
      evt_rx_pkt   <= 1'b0;
      evt_remote   <= 1'b0;
      evt_short    <= 1'b0;
      evt_align    <= 1'b0;
      evt_crc      <= 1'b0;
      evt_overflow <= 1'b0;
    end else begin
      dec_valid              <= 1'b1;
      dec_store              <= allowed && !buf_full;
      hdr_status             <= '0;
      hdr_status[HDR_REMOTE] <= fl.remote;
      hdr_status[HDR_SHORT]  <= fl.short_err;
      hdr_status[HDR_ALIGN]  <= fl.align_err;
      hdr_status[HDR_CRC]    <= fl.crc_err;
      evt_rx_pkt             <= allowed && !buf_full;
      evt_remote             <= allowed && !buf_full && fl.remote;
      evt_short              <= allowed && !buf_full && fl.short_err;
      evt_align              <= allowed && !buf_full && fl.align_err;
      evt_crc                <= allowed && !buf_full && fl.crc_err;
      evt_overflow           <= allowed && buf_full;
    end
  end

  assert_ovf_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow |-> $past(buf_full));
  assert_short_kept_permitted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_store && hdr_status[HDR_SHORT]) |-> $past(cfg_accept_short));
  assert_bad_kept_permitted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_store && (hdr_status[HDR_CRC] || hdr_status[HDR_ALIGN])) |-> $past(cfg_accept_bad));
endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate #(
  parameter int          CNT_W       = 11,
  parameter int          MIN_LEN     = 60,
  parameter int          FCS_BYTES   = 4,
  parameter int          TYPE_OFS    = 12,
  parameter logic [15:0] REMOTE_TYPE = 16'h0900
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic [2:0] in_tail_bits,
  input  logic       cfg_accept_bad,
  input  logic       cfg_accept_short,
  input  logic       cfg_remote_en,
  input  logic       buf_full,
  output logic       dec_valid,
  output logic       dec_store,
  output logic [7:0] hdr_status,
  output logic       evt_rx_pkt,
  output logic       evt_remote,
  output logic       evt_short,
  output logic       evt_align,
  output logic       evt_crc,
  output logic       evt_overflow
);
  logic             beat;
  logic             eof;
  logic             crc_ok_nxt;
  logic [CNT_W-1:0] len_nxt;
  logic [15:0]      type_nxt;
  logic             type_seen;

  assign in_ready = !dec_valid;
  assign beat     = in_valid && in_ready;
  assign eof      = beat && in_last;

  rxacc_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(in_last),
    .data(in_data), .crc_ok_nxt(crc_ok_nxt)
  );

  rxacc_field_track #(.CNT_W(CNT_W), .TYPE_OFS(TYPE_OFS)) u_track (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(in_last), .data(in_data),
    .len_nxt(len_nxt), .type_nxt(type_nxt), .type_seen(type_seen)
  );

  rxacc_decide #(
    .CNT_W(CNT_W), .MIN_LEN(MIN_LEN), .FCS_BYTES(FCS_BYTES), .REMOTE_TYPE(REMOTE_TYPE)
  ) u_decide (
    .clk(clk), .rst_n(rst_n), .eof(eof), .len(len_nxt), .crc_ok(crc_ok_nxt),
    .tail_bits(in_tail_bits), .type_val(type_nxt), .type_seen(type_seen),
    .cfg_accept_bad(cfg_accept_bad), .cfg_accept_short(cfg_accept_short),
    .cfg_remote_en(cfg_remote_en), .buf_full(buf_full),
    .dec_valid(dec_valid), .dec_store(dec_store), .hdr_status(hdr_status),
    .evt_rx_pkt(evt_rx_pkt), .evt_remote(evt_remote), .evt_short(evt_short),
    .evt_align(evt_align), .evt_crc(evt_crc), .evt_overflow(evt_overflow)
  );

  assert_single_decision_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  assert_decision_follows_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_last));
  assert_events_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !(evt_rx_pkt || evt_remote || evt_short || evt_align || evt_crc || evt_overflow));
  assert_store_or_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dec_store, evt_overflow}) <= 1);
  assert_hdr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (hdr_status == 8'h00));
endmodule

// File: tb/rx_frame_gate_bench.sv
module rx_frame_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic [2:0] in_tail_bits = '0;
  logic       cfg_accept_bad = 1'b0;
  logic       cfg_accept_short = 1'b0;
  logic       cfg_remote_en = 1'b0;
  logic       buf_full = 1'b0;
  logic       dec_valid, dec_store;
  logic [7:0] hdr_status;
  logic       evt_rx_pkt, evt_remote, evt_short, evt_align, evt_crc, evt_overflow;

  always #4 clk = ~clk;

  rx_frame_gate u_rx_frame_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_tail_bits(in_tail_bits),
    .cfg_accept_bad(cfg_accept_bad), .cfg_accept_short(cfg_accept_short),
    .cfg_remote_en(cfg_remote_en), .buf_full(buf_full),
    .dec_valid(dec_valid), .dec_store(dec_store), .hdr_status(hdr_status),
    .evt_rx_pkt(evt_rx_pkt), .evt_remote(evt_remote), .evt_short(evt_short),
    .evt_align(evt_align), .evt_crc(evt_crc), .evt_overflow(evt_overflow)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic logic [31:0] fcs_of(byte unsigned q[$], int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = ((c[0] ^ q[i][b]) != 1'b0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return ~c;
  endfunction

  // behavioural reference model
  byte unsigned rxq[$];
  logic m_dv, m_store, m_ovf;
  logic [7:0] m_hdr;
  logic m_rx, m_rem, m_sh, m_al, m_cr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dv <= 0; m_store <= 0; m_ovf <= 0; m_hdr <= 0;
      m_rx <= 0; m_rem <= 0; m_sh <= 0; m_al <= 0; m_cr <= 0;
      rxq.delete();
    end else if (m_dv) begin
      m_dv <= 0; m_store <= 0; m_ovf <= 0; m_hdr <= 0;
      m_rx <= 0; m_rem <= 0; m_sh <= 0; m_al <= 0; m_cr <= 0;
    end else if (in_valid) begin
      rxq.push_back(in_data);
      if (in_last) begin
        int n;
        bit sh, al, cr, rem, ok;
        logic [31:0] got;
        n   = rxq.size();
        sh  = (n - 4) < 60;
        al  = in_tail_bits != 0;
        got = {rxq[n-1], rxq[n-2], rxq[n-3], rxq[n-4]};
        cr  = got != fcs_of(rxq, n - 4);
        rem = cfg_remote_en && n >= 14 && rxq[12] == 8'h09 && rxq[13] == 8'h00;
        ok  = !(sh && !cfg_accept_short) && !((cr || al) && !cfg_accept_bad);
        m_dv <= 1;
        m_store <= ok && !buf_full;
        m_ovf <= ok && buf_full;
        m_hdr <= {3'b000, rem, sh, al, cr, 1'b0};
        m_rx <= ok && !buf_full;
        m_rem <= ok && !buf_full && rem;
        m_sh <= ok && !buf_full && sh;
        m_al <= ok && !buf_full && al;
        m_cr <= ok && !buf_full && cr;
        rxq.delete();
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cycles++;
      chk("R1 in_ready", in_ready, !m_dv);
      chk("R2 dec_valid", dec_valid, m_dv);
      chk("R7 dec_store", dec_store, m_store);
      chk("R3 hdr short bit", hdr_status[3], m_hdr[3]);
      chk("R4 hdr align bit", hdr_status[2], m_hdr[2]);
      chk("R5 hdr crc bit", hdr_status[1], m_hdr[1]);
      chk("R6 hdr remote bit", hdr_status[4], m_hdr[4]);
      chk("R8 hdr spare bits", {hdr_status[7:5], hdr_status[0]}, 4'h0);
      chk("R9 evt_overflow", evt_overflow, m_ovf);
      chk("R10 events", {evt_rx_pkt, evt_remote, evt_short, evt_align, evt_crc},
          {m_rx, m_rem, m_sh, m_al, m_cr});
      if (cycles > 100000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic send(int nbytes, bit bad_crc, int tail, logic [15:0] typ,
                      bit abad, bit ashort, bit ren, bit full);
    byte unsigned f[$];
    logic [31:0] c;
    int i;
    for (int k = 0; k < nbytes - 4; k++) f.push_back(byte'($urandom));
    if (nbytes - 4 >= 14) begin
      f[12] = typ[15:8];
      f[13] = typ[7:0];
    end
    c = fcs_of(f, nbytes - 4);
    for (int k = 0; k < 4; k++) f.push_back(c[8*k +: 8]);
    if (bad_crc) f[nbytes/2] = f[nbytes/2] ^ 8'h10;
    i = 0;
    while (i < nbytes) begin
      @(negedge clk);
      cfg_accept_bad = abad; cfg_accept_short = ashort;
      cfg_remote_en = ren; buf_full = full;
      if (($urandom % 5) == 0) begin
        in_valid = 0;
      end else begin
        in_valid = 1;
        in_data = f[i];
        in_last = (i == nbytes - 1);
        in_tail_bits = (i == nbytes - 1) ? 3'(tail) : 3'd0;
        if (in_ready) i++;
      end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; in_tail_bits = 0;
    buf_full = ($urandom % 2) != 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 dec_valid", dec_valid, 0);
    chk("R11 hdr_status", hdr_status, 0);
    chk("R11 events", {evt_rx_pkt, evt_remote, evt_short, evt_align, evt_crc, evt_overflow}, 0);
    chk("R11 dec_store", dec_store, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after reset", in_ready, 1);
    send(64, 0, 0, 16'h0800, 0, 0, 0, 0);  // minimum good length, R3 boundary
    send(63, 0, 0, 16'h0800, 0, 0, 0, 0);  // R3 short, discarded (R7)
    send(63, 0, 0, 16'h0800, 0, 1, 0, 0);  // R3 short kept
    send(80, 1, 0, 16'h0800, 0, 0, 0, 0);  // R5 crc error discarded
    send(80, 1, 0, 16'h0800, 1, 0, 0, 0);  // R5 crc error kept
    send(70, 0, 3, 16'h0800, 1, 0, 0, 0);  // R4 alignment kept
    send(70, 0, 7, 16'h0800, 0, 1, 0, 0);  // R4 alignment discarded
    send(72, 0, 0, 16'h0900, 0, 0, 1, 0);  // R6 remote
    send(72, 0, 0, 16'h0900, 0, 0, 0, 0);  // R6 disabled
    send(72, 0, 0, 16'h0901, 0, 0, 1, 0);  // R6 wrong type
    send(40, 0, 0, 16'h0900, 0, 1, 1, 0);  // R6 with R3 in one cycle
    send(40, 1, 0, 16'h0800, 0, 1, 0, 0);  // R7 short+crc, only short allowed
    send(90, 0, 0, 16'h0800, 0, 0, 0, 1);  // R9 overflow
    send(90, 1, 0, 16'h0800, 0, 0, 0, 1);  // R9 unacceptable, no overflow
    send(10, 0, 0, 16'h0900, 1, 1, 1, 0);  // tiny frame, no remote
    for (int r = 0; r < 40; r++)
      send(20 + ($urandom % 100), ($urandom % 3) == 0, ($urandom % 4 == 0) ? 1 + $urandom % 7 : 0,
           ($urandom % 2) ? 16'h0900 : 16'h86DD, $urandom % 2, $urandom % 2,
           $urandom % 2, ($urandom % 4) == 0);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule